// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits beside a root port and records the error messages that reach it, so that software can later learn what went wrong and who reported it. Each event has a severity (correctable, non-fatal or fatal) and a 16-bit requester ID. Events come from two places: messages that other devices send to the port, and errors the port finds itself. The port's own errors are logged with the port's own ID. Non-fatal and fatal events share one uncorrectable category. Correctable events form the second category.

For each category the block keeps two flags. The first flag marks that an error arrived. The second flag marks that a further error of the same category arrived before software cleared the first. Only the first sender's ID is kept. A small command register holds one interrupt enable per severity. The block drives a level interrupt from the status flags and these enables. Software reads and writes three 32-bit registers through a simple port. Reads have one cycle of latency, and status bits are cleared by writing 1 to them.

Top module: `rp_err_collector`

## Requirements
- R1: After the synchronous active-high reset, the command, status and source ID registers read as zero and `irq` is 0.
- R2: Severity codes are 0 = correctable, 1 = non-fatal, 2 = fatal and 3 = no event, which changes nothing. Non-fatal and fatal events set status bit 2 (uncorrectable received). Correctable events set status bit 0.
- R3: When an event arrives in a category whose first bit (bit 0 or bit 2) is clear, the block sets that bit. It also stores the requester ID in the source ID register: bits 15:0 for correctable, bits 31:16 for uncorrectable.
- R4: When an event arrives in a category whose first bit is already set, the block sets the next bit (bit 1 or bit 3) and leaves the stored ID unchanged.
- R5: Writing the status register (address 1) clears each of bits 6:0 where the written data has a 1. Bits written with 0 keep their value.
- R6: If a clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R7: The command register (address 0) stores written bits 2:0: bit 2 is the fatal enable, bit 1 the non-fatal enable, bit 0 the correctable enable. Bits 31:3 read as zero.
- R8: `irq` equals (bit 0 AND enable 0) OR (bit 5 AND enable 1) OR (bit 6 AND enable 2). Status bits and ID logging update whatever the enables are.
- R9: A self-detected error (`self_valid`) is handled exactly like a received message, with `own_id` as its requester ID. If a received message and a self-detected error of the same category arrive together while the first bit is clear, the message's ID is logged and the next bit is also set.
- R10: In the status register, bit 4 shows whether the event that set bit 2 was fatal, bit 5 is set by any non-fatal event and bit 6 by any fatal event. Bits 31:27 show `msg_num`.
- R11: `reg_rdata` shows, one cycle later, the register selected by `reg_addr`. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | A received error message is present this cycle |
| msg_sev | input | 2 | Severity of the received message |
| msg_rid | input | 16 | Requester ID of the received message |
| self_valid | input | 1 | The port detected an error itself this cycle |
| self_sev | input | 2 | Severity of the self-detected error |
| own_id | input | 16 | The port's own requester ID |
| msg_num | input | 5 | Static interrupt message number, shown in the status register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 source ID |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request level |

## Verification
The bench targets three collisions. The first is a same-cycle clear and new event: a design that lets the clear win would lose an error. The second is a message and a self-detected error of one category arriving together: a wrong design would log the port's ID instead of the message's, or miss the next bit. The third is a repeat error while the first bit is set: a wrong design would overwrite the logged requester ID. The bench also writes zeros to status, writes ones to the unused command bits and sends the no-event severity code, to show that none of these changes state. A long random run with changing enables then checks that `irq` follows status and enables without either one steering the other.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_NONE     = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_STAT = 2'd1,
    A_SRC  = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  localparam int NUM_CAT = 2;   // 0: correctable, 1: uncorrectable
  localparam int ST_W    = 7;   // status flag bits
  localparam int CMD_W   = 3;   // interrupt enable bits

endpackage

// File: rtl/rp_err_classify.sv
module rp_err_classify
  import rp_err_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic                         msg_valid,
  input  logic [1:0]                   msg_sev,
  input  logic [ID_W-1:0]              msg_rid,
  input  logic                         self_valid,
  input  logic [1:0]                   self_sev,
  input  logic [ID_W-1:0]              own_id,
  output logic [NUM_CAT-1:0]           hit_o,
  output logic [NUM_CAT-1:0]           dbl_o,
  output logic [NUM_CAT-1:0][ID_W-1:0] id_o,
  output logic                         unc_fatal_o,
  output logic                         nf_any_o,
  output logic                         fat_any_o
);

  logic m_cor, m_nf, m_fat, m_unc;
  logic s_cor, s_nf, s_fat, s_unc;

  always_comb begin
    m_cor = msg_valid  && (msg_sev  == SEV_COR);
    m_nf  = msg_valid  && (msg_sev  == SEV_NONFATAL);
    m_fat = msg_valid  && (msg_sev  == SEV_FATAL);
    s_cor = self_valid && (self_sev == SEV_COR);
    s_nf  = self_valid && (self_sev == SEV_NONFATAL);
    s_fat = self_valid && (self_sev == SEV_FATAL);
    m_unc = m_nf | m_fat;
    s_unc = s_nf | s_fat;

    // received messages take priority for the logged ID
    hit_o[0] = m_cor | s_cor;
    dbl_o[0] = m_cor & s_cor;
    id_o[0]  = m_cor ? msg_rid : own_id;

    hit_o[1] = m_unc | s_unc;
    dbl_o[1] = m_unc & s_unc;
    id_o[1]  = m_unc ? msg_rid : own_id;

    unc_fatal_o = m_unc ? m_fat : s_fat;
    nf_any_o    = m_nf | s_nf;
    fat_any_o   = m_fat | s_fat;
  end

endmodule

// File: rtl/rp_err_cat.sv
module rp_err_cat #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  input  logic            dbl,
  input  logic [ID_W-1:0] hit_id,
  input  logic            clr_first,
  input  logic            clr_next,
  output logic            first_o,
  output logic            next_o,
  output logic [ID_W-1:0] id_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_o <= 1'b0;
      next_o  <= 1'b0;
      id_o    <= '0;
    end else begin
      if (hit)            first_o <= 1'b1;
      else if (clr_first) first_o <= 1'b0;

      if ((hit && first_o) || dbl) next_o <= 1'b1;
      else if (clr_next)           next_o <= 1'b0;

      if (hit && !first_o) id_o <= hit_id;
    end
  end

  p_first_set_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> first_o);

  p_log_id_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && !first_o) |=> (id_o == $past(hit_id)));

  p_id_kept_r4: assert property (@(posedge clk) disable iff (rst)
    first_o |=> (id_o == $past(id_o)));

  p_next_set_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && first_o) |=> next_o);

  p_w1c_first_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_first && !hit) |=> !first_o);

  p_clear_loses_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_next && hit && first_o) |=> next_o);

endmodule

// File: rtl/rp_err_regif.sv
module rp_err_regif
  import rp_err_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MSGNUM_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [ST_W-1:0]     stat_bits,
  input  logic [DATA_W-1:0]   src_word,
  input  logic [MSGNUM_W-1:0] msg_num,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [ST_W-1:0]     clr_o,
  output logic [DATA_W-1:0]   rdata
);

  localparam int PAD_W = DATA_W - MSGNUM_W - ST_W;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] cmd_word;
  logic              unused_wdata;

  assign stat_word    = {msg_num, {PAD_W{1'b0}}, stat_bits};
  assign cmd_word     = {{(DATA_W-CMD_W){1'b0}}, cmd_o};
  assign clr_o        = (wr && addr == A_STAT) ? wdata[ST_W-1:0] : '0;
  assign unused_wdata = ^wdata[DATA_W-1:ST_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o <= '0;
      rdata <= '0;
    end else begin
      if (wr && addr == A_CMD) cmd_o <= wdata[CMD_W-1:0];
      case (addr)
        A_CMD:   rdata <= cmd_word;
        A_STAT:  rdata <= stat_word;
        A_SRC:   rdata <= src_word;
        default: rdata <= '0;
      endcase
    end
  end

  p_cmd_pad_r7: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CMD) |=> (rdata[DATA_W-1:CMD_W] == '0));

  p_msgnum_r10: assert property (@(posedge clk) disable iff (rst)
    (addr == A_STAT) |=> (rdata[DATA_W-1 -: MSGNUM_W] == $past(msg_num)));

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (addr == A_RSVD) |=> (rdata == '0));

endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rp_err_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int DATA_W   = 32,
  parameter int MSGNUM_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                msg_valid,
  input  logic [1:0]          msg_sev,
  input  logic [ID_W-1:0]     msg_rid,
  input  logic                self_valid,
  input  logic [1:0]          self_sev,
  input  logic [ID_W-1:0]     own_id,
  input  logic [MSGNUM_W-1:0] msg_num,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);

  logic [NUM_CAT-1:0]           cat_hit, cat_dbl, cat_first, cat_next;
  logic [NUM_CAT-1:0][ID_W-1:0] cat_in_id, cat_id;
  logic                         unc_fatal, nf_any, fat_any;
  logic                         ffat_q, nf_q, fat_q;
  logic [ST_W-1:0]              stat, clr;
  logic [CMD_W-1:0]             cmd;
  logic [DATA_W-1:0]            src_word;

  rp_err_classify #(.ID_W(ID_W)) u_cls (
    .msg_valid  (msg_valid),
    .msg_sev    (msg_sev),
    .msg_rid    (msg_rid),
    .self_valid (self_valid),
    .self_sev   (self_sev),
    .own_id     (own_id),
    .hit_o      (cat_hit),
    .dbl_o      (cat_dbl),
    .id_o       (cat_in_id),
    .unc_fatal_o(unc_fatal),
    .nf_any_o   (nf_any),
    .fat_any_o  (fat_any)
  );

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    rp_err_cat #(.ID_W(ID_W)) u_cat (
      .clk      (clk),
      .rst      (rst),
      .hit      (cat_hit[c]),
      .dbl      (cat_dbl[c]),
      .hit_id   (cat_in_id[c]),
      .clr_first(clr[2*c]),
      .clr_next (clr[2*c+1]),
      .first_o  (cat_first[c]),
      .next_o   (cat_next[c]),
      .id_o     (cat_id[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ffat_q <= 1'b0;
      nf_q   <= 1'b0;
      fat_q  <= 1'b0;
    end else begin
      if (cat_hit[1] && !cat_first[1]) ffat_q <= unc_fatal;
      else if (clr[4])                 ffat_q <= 1'b0;
      if (nf_any)      nf_q <= 1'b1;
      else if (clr[5]) nf_q <= 1'b0;
      if (fat_any)     fat_q <= 1'b1;
      else if (clr[6]) fat_q <= 1'b0;
    end
  end

  assign stat     = {fat_q, nf_q, ffat_q, cat_next[1], cat_first[1], cat_next[0], cat_first[0]};
  assign src_word = DATA_W'({cat_id[1], cat_id[0]});
  assign irq      = (stat[0] & cmd[0]) | (stat[5] & cmd[1]) | (stat[6] & cmd[2]);

  rp_err_regif #(.DATA_W(DATA_W), .MSGNUM_W(MSGNUM_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat_bits(stat),
    .src_word (src_word),
    .msg_num  (msg_num),
    .cmd_o    (cmd),
    .clr_o    (clr),
    .rdata    (reg_rdata)
  );

  p_unc_group_r2: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL)) |=> stat[2]);

  p_fatal_seen_r10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == SEV_FATAL) |=> stat[6]);

  p_self_id_r9: assert property (@(posedge clk) disable iff (rst)
    (self_valid && self_sev == SEV_COR && !(msg_valid && msg_sev == SEV_COR) && !stat[0])
      |=> (src_word[ID_W-1:0] == $past(own_id)));

  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat[0] || stat[5] || stat[6]));

endmodule

// File: tb/sim_rp_err_collector.sv
module sim_rp_err_collector;
  localparam int ID_W = 16, DATA_W = 32, MSGNUM_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst;
  logic                msg_valid, self_valid, reg_wr;
  logic [1:0]          msg_sev, self_sev, reg_addr;
  logic [ID_W-1:0]     msg_rid, own_id;
  logic [MSGNUM_W-1:0] msg_num;
  logic [DATA_W-1:0]   reg_wdata, reg_rdata;
  logic                irq;

  rp_err_collector u0 (.*);

  int    n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";

  // reference model state
  logic [2:0]      m_cmd;
  logic [6:0]      m_st;
  logic [ID_W-1:0] m_cid, m_uid;

  function automatic logic [31:0] mread(logic [1:0] a);
    case (a)
      2'd0:    return {29'b0, m_cmd};
      2'd1:    return {msg_num, 20'b0, m_st};
      2'd2:    return {m_uid, m_cid};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_st[0] & m_cmd[0]) | (m_st[5] & m_cmd[1]) | (m_st[6] & m_cmd[2]);
  endfunction

  task automatic model_step();
    logic [1:0] ms, ss;
    logic mc, mn, mf, mu, sc, sn, sf, su;
    logic [6:0] clr, nst;
    ms = msg_valid ? msg_sev : 2'd3;
    ss = self_valid ? self_sev : 2'd3;
    mc = ms == 2'd0; mn = ms == 2'd1; mf = ms == 2'd2; mu = mn | mf;
    sc = ss == 2'd0; sn = ss == 2'd1; sf = ss == 2'd2; su = sn | sf;
    clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[6:0] : 7'b0;
    nst = m_st;
    if (mc | sc) begin
      nst[0] = 1'b1;
      if (!m_st[0]) m_cid = mc ? msg_rid : own_id;
    end else if (clr[0]) nst[0] = 1'b0;
    if ((mc | sc) && (m_st[0] || (mc && sc))) nst[1] = 1'b1;
    else if (clr[1]) nst[1] = 1'b0;
    if (mu | su) begin
      nst[2] = 1'b1;
      if (!m_st[2]) m_uid = mu ? msg_rid : own_id;
    end else if (clr[2]) nst[2] = 1'b0;
    if ((mu | su) && (m_st[2] || (mu && su))) nst[3] = 1'b1;
    else if (clr[3]) nst[3] = 1'b0;
    if ((mu | su) && !m_st[2]) nst[4] = mu ? mf : sf;
    else if (clr[4]) nst[4] = 1'b0;
    if (mn | sn) nst[5] = 1'b1; else if (clr[5]) nst[5] = 1'b0;
    if (mf | sf) nst[6] = 1'b1; else if (clr[6]) nst[6] = 1'b0;
    if (reg_wr && reg_addr == 2'd0) m_cmd = reg_wdata[2:0];
    m_st = nst;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] e;
    e = mread(reg_addr);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_tag, reg_rdata, e);
    chk("R8", {31'b0, irq}, {31'b0, m_irq()});
  endtask

  task automatic idle();
    msg_valid = 0; self_valid = 0; reg_wr = 0; reg_addr = 2'd0; reg_wdata = '0;
    msg_sev = 2'd3; self_sev = 2'd3; msg_rid = '0;
  endtask

  task automatic rd(logic [1:0] a);
    idle(); reg_addr = a; tick();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic msg(logic [1:0] s, logic [15:0] id);
    idle(); msg_valid = 1; msg_sev = s; msg_rid = id; tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    own_id = 16'hABCD; msg_num = 5'h15; rst = 1;
    m_cmd = '0; m_st = '0; m_cid = '0; m_uid = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_tag = "R1";  rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);
    cur_tag = "R3";  msg(2'd0, 16'h1111); rd(2'd1); rd(2'd2);
    cur_tag = "R2";  msg(2'd1, 16'h2222); rd(2'd1); rd(2'd2);
                     msg(2'd3, 16'h9999); rd(2'd1); rd(2'd2);
    cur_tag = "R4";  msg(2'd0, 16'h3333); msg(2'd2, 16'h4444); rd(2'd1); rd(2'd2);
    cur_tag = "R5";  wr(2'd1, 32'h0); rd(2'd1); wr(2'd1, 32'h0000_0003); rd(2'd1);
                     wr(2'd1, 32'hFFFF_FFFF); rd(2'd1);
    cur_tag = "R6";  msg(2'd0, 16'h6666);
                     idle(); reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h3;
                     msg_valid = 1; msg_sev = 2'd0; msg_rid = 16'h7777; tick();
                     rd(2'd1); rd(2'd2);
    cur_tag = "R7";  wr(2'd0, 32'hFFFF_FFFF); rd(2'd0); wr(2'd0, 32'h0000_0002); rd(2'd0);
    cur_tag = "R8";  wr(2'd0, 32'h1); rd(2'd1); wr(2'd0, 32'h0); msg(2'd0, 16'h0001); rd(2'd1);
    cur_tag = "R9";  wr(2'd1, 32'h7F);
                     idle(); self_valid = 1; self_sev = 2'd2; tick(); rd(2'd1); rd(2'd2);
                     wr(2'd1, 32'h7F);
                     idle(); self_valid = 1; self_sev = 2'd0;
                     msg_valid = 1; msg_sev = 2'd0; msg_rid = 16'h5A5A; tick();
                     rd(2'd1); rd(2'd2);
    cur_tag = "R10"; wr(2'd1, 32'h7F); msg(2'd1, 16'h0101); msg(2'd2, 16'h0202); rd(2'd1);
                     wr(2'd1, 32'h10); rd(2'd1); msg_num = 5'h0A; rd(2'd1);

    cur_tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      msg_valid  = ($urandom % 4) == 0;
      msg_sev    = 2'($urandom);
      msg_rid    = 16'($urandom);
      self_valid = ($urandom % 8) == 0;
      self_sev   = 2'($urandom);
      if (($urandom % 64) == 0) own_id = 16'($urandom);
      reg_wr     = ($urandom % 5) == 0;
      reg_addr   = 2'($urandom);
      reg_wdata  = $urandom;
      tick();
    end

    summary();
    $finish;
  end

endmodule